// File: doc/BRIEF.md
# SD Command Issue and Auto-Stop Unit

This unit sits between a host command register and a simplified card-side command port. A write to the command word that has the start bit set launches one command toward the card. The unit then waits a programmable number of cycles for the card's answer and stores the answer in four 32-bit response words. It reports the outcome in a sticky raw status word, using the command-done bit or the no-answer bit. A command can also be marked as a clock-change only command. Such a command never reaches the card but still completes.

When the stored command has its auto-stop flag set and the transfer counter reports zero, the unit sends a stop command (index 12, argument 0) on its own. The host-visible command and argument words are left exactly as the host wrote them, and an auto-done status bit is raised. The zero check runs at three points: when a command finishes, on a DMA-finished pulse, and on every 32-bit FIFO access pulse.

The sequencer has six states. IDLE accepts work. SEND drives the one-cycle request. WAIT counts toward the timeout. CHECK decides whether to stop. STOP_SEND and STOP_WAIT carry the stop command. The transitions are:
- IDLE→SEND on a load.
- IDLE→CHECK on a clock-change load.
- IDLE→STOP_SEND on a qualifying DMA or FIFO event.
- SEND→WAIT.
- WAIT→CHECK on an answer or a timeout.
- CHECK→STOP_SEND when auto-stop applies, otherwise CHECK→IDLE.
- STOP_SEND→STOP_WAIT.
- STOP_WAIT→IDLE on an answer or a timeout.

Top module: `sd_cmd_issue`

## Requirements
- R1: A command write in IDLE with bit 31 set starts a command, and the stored command word reads back with bit 31 cleared. A command write without bit 31 only stores the word and sends nothing.
- R2: A started command produces exactly one cycle of `card_req`, carrying index = command bits [5:0] and the stored argument.
- R3: A started command with bit 21 set sends nothing to the card and sets raw status bit 2 (command done).
- R4: With bit 6 set and bit 7 clear, a 4-byte answer is stored big-endian into word 0, byte 0 being the most significant. Words 1 to 3 are cleared.
- R5: With bits 6 and 7 set, a 16-byte answer is stored big-endian in reversed word order: word 0 takes bytes 12..15, word 1 bytes 8..11, word 2 bytes 4..7 and word 3 bytes 0..3.
- R6: When a response is expected and the answer length does not match the requested kind, raw status bit 1 (no answer) is set instead of bit 2, and the response words keep their values. With bit 6 clear, any answer sets bit 2 and leaves the response words unchanged.
- R7: An answer is accepted only if it arrives within the first `tmo_limit` cycles of the wait. Otherwise the command ends with raw status bit 1.
- R8: When bit 12 (auto-stop) of the stored command is set and `xfer_zero` is high at the end of a command, index 12 with argument 0 is sent next. The stop's outcome is reported through bit 2 or bit 1, raw status bit 14 is then set, and the command and argument words are left unchanged.
- R9: In IDLE, a `dma_done` or `fifo_access` pulse starts the same stop sequence when bit 12 is stored and `xfer_zero` is high. It starts nothing otherwise.
- R10: `busy` is high outside IDLE. Command and argument writes made while busy are ignored, so no second command starts.
- R11: Writing `stat_clr_mask` with `stat_clr_wr` clears the raw status bits written as one and keeps the others.
- R12: With bit 12 set but `xfer_zero` low, a finished command sends no stop and bit 14 stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word written |
| arg_wr | input | 1 | Argument word write strobe |
| arg_wdata | input | 32 | Argument word written |
| stat_clr_wr | input | 1 | Raw status clear strobe |
| stat_clr_mask | input | 32 | Ones clear the matching status bits |
| xfer_zero | input | 1 | Remaining transfer count is zero |
| dma_done | input | 1 | DMA finished pulse |
| fifo_access | input | 1 | 32-bit FIFO access pulse |
| tmo_limit | input | TMO_W | Answer wait limit in cycles |
| card_req | output | 1 | One-cycle command request to the card |
| card_cmd_idx | output | 6 | Command index sent |
| card_arg | output | 32 | Argument sent |
| card_resp_valid | input | 1 | Card answer strobe |
| card_resp_len | input | LEN_W | Answer length in bytes |
| card_resp_bytes | input | 8*RESP_BYTES | Answer bytes, byte i at bits [8i+7:8i] |
| busy | output | 1 | Sequence in progress |
| cmd_reg | output | 32 | Stored command word |
| arg_reg | output | 32 | Stored argument word |
| resp_word0 | output | 32 | Response word 0 |
| resp_word1 | output | 32 | Response word 1 |
| resp_word2 | output | 32 | Response word 2 |
| resp_word3 | output | 32 | Response word 3 |
| raw_status | output | 32 | Sticky status: bit 1 no answer, bit 2 done, bit 14 auto-stop done |

## Verification
The bench builds the unit with `TMO_W` = 6, keeping `RESP_BYTES` at 16. The narrow timer field keeps each timeout run to a handful of cycles, so the accept and reject edges at one cycle either side of the limit can be probed directly. The card model answers after a chosen delay with a chosen length. This lets each test pair a command kind with a matching answer, a mismatched answer, no answer at all, and chained stop commands.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEND,
        S_WAIT,
        S_CHECK,
        S_STOP_SEND,
        S_STOP_WAIT
    } seq_state_t;

    // command word field positions
    localparam int unsigned CF_LOAD     = 31;
    localparam int unsigned CF_CLKCHG   = 21;
    localparam int unsigned CF_AUTOSTOP = 12;
    localparam int unsigned CF_LONG     = 7;
    localparam int unsigned CF_RESP     = 6;

    // raw status bit positions
    localparam int unsigned ST_NOANS  = 1;
    localparam int unsigned ST_DONE   = 2;
    localparam int unsigned ST_AUTO   = 14;

    localparam logic [5:0] STOP_INDEX = 6'd12;
    localparam int unsigned SHORT_BYTES = 4;

endpackage

// File: rtl/sd_resp_pack.sv
module sd_resp_pack #(
    parameter int unsigned RESP_BYTES = 16,
    parameter int unsigned LEN_W      = $clog2(RESP_BYTES + 1)
) (
    input  logic                    long_sel,
    input  logic [LEN_W-1:0]        resp_len,
    input  logic [8*RESP_BYTES-1:0] resp_bytes,
    output logic [RESP_BYTES/4-1:0][31:0] words,
    output logic                    len_ok
);
    import sd_cmd_pkg::*;

    localparam int unsigned WORDS = RESP_BYTES / 4;

    assign len_ok = long_sel ? (resp_len == LEN_W'(RESP_BYTES))
                             : (resp_len == LEN_W'(SHORT_BYTES));

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam int unsigned LB = (WORDS - 1 - w) * 4;
        logic [31:0] long_w;
        logic [31:0] short_w;

        assign long_w = {resp_bytes[8*LB +: 8], resp_bytes[8*(LB+1) +: 8],
                         resp_bytes[8*(LB+2) +: 8], resp_bytes[8*(LB+3) +: 8]};

        if (w == 0) begin : g_first
            assign short_w = {resp_bytes[7:0], resp_bytes[15:8],
                              resp_bytes[23:16], resp_bytes[31:24]};
        end else begin : g_rest
            assign short_w = '0;
        end

        assign words[w] = long_sel ? long_w : short_w;
    end

endmodule

// File: rtl/sd_wait_timer.sv
module sd_wait_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit});

    // R7
    expire_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !run);

endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue #(
    parameter int unsigned TMO_W      = 16,
    parameter int unsigned RESP_BYTES = 16,
    parameter int unsigned LEN_W      = $clog2(RESP_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_wr,
    input  logic [31:0]             cmd_wdata,
    input  logic                    arg_wr,
    input  logic [31:0]             arg_wdata,
    input  logic                    stat_clr_wr,
    input  logic [31:0]             stat_clr_mask,
    input  logic                    xfer_zero,
    input  logic                    dma_done,
    input  logic                    fifo_access,
    input  logic [TMO_W-1:0]        tmo_limit,
    output logic                    card_req,
    output logic [5:0]              card_cmd_idx,
    output logic [31:0]             card_arg,
    input  logic                    card_resp_valid,
    input  logic [LEN_W-1:0]        card_resp_len,
    input  logic [8*RESP_BYTES-1:0] card_resp_bytes,
    output logic                    busy,
    output logic [31:0]             cmd_reg,
    output logic [31:0]             arg_reg,
    output logic [31:0]             resp_word0,
    output logic [31:0]             resp_word1,
    output logic [31:0]             resp_word2,
    output logic [31:0]             resp_word3,
    output logic [31:0]             raw_status
);
    import sd_cmd_pkg::*;

    localparam int unsigned WORDS = RESP_BYTES / 4;

    seq_state_t state_q, state_d;
    logic [31:0] cmd_q, arg_q, status_q, status_set;
    logic [WORDS-1:0][31:0] resp_q, packed_words;
    logic len_ok, tmo_hit, in_wait, in_stop, answer, answer_ok;
    logic load_go, evt_stop, stop_due, finish;

    assign in_wait   = (state_q == S_WAIT) || (state_q == S_STOP_WAIT);
    assign in_stop   = (state_q == S_STOP_SEND) || (state_q == S_STOP_WAIT);
    assign answer    = in_wait && card_resp_valid;
    assign answer_ok = !cmd_q[CF_RESP] || len_ok;
    assign load_go   = (state_q == S_IDLE) && cmd_wr && cmd_wdata[CF_LOAD];
    assign stop_due  = cmd_q[CF_AUTOSTOP] && xfer_zero;
    assign evt_stop  = (dma_done || fifo_access) && stop_due;

    logic tmo_expired;
    assign tmo_hit = tmo_expired && !card_resp_valid;
    assign finish  = answer || tmo_hit;

    sd_wait_timer #(.CNT_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (card_req),
        .run     (in_wait),
        .limit   (tmo_limit),
        .expired (tmo_expired)
    );

    sd_resp_pack #(.RESP_BYTES(RESP_BYTES), .LEN_W(LEN_W)) u_pack (
        .long_sel   (cmd_q[CF_LONG]),
        .resp_len   (card_resp_len),
        .resp_bytes (card_resp_bytes),
        .words      (packed_words),
        .len_ok     (len_ok)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (load_go)       state_d = cmd_wdata[CF_CLKCHG] ? S_CHECK : S_SEND;
                else if (evt_stop) state_d = S_STOP_SEND;
            end
            S_SEND:      state_d = S_WAIT;
            S_WAIT:      if (finish) state_d = S_CHECK;
            S_CHECK:     state_d = stop_due ? S_STOP_SEND : S_IDLE;
            S_STOP_SEND: state_d = S_STOP_WAIT;
            S_STOP_WAIT: if (finish) state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        card_req     = (state_q == S_SEND) || (state_q == S_STOP_SEND);
        card_cmd_idx = in_stop ? STOP_INDEX : cmd_q[5:0];
        card_arg     = in_stop ? 32'd0 : arg_q;
        busy         = (state_q != S_IDLE);
        status_set   = '0;
        if (load_go && cmd_wdata[CF_CLKCHG]) status_set[ST_DONE] = 1'b1;
        if (answer && answer_ok)             status_set[ST_DONE] = 1'b1;
        if ((answer && !answer_ok) || tmo_hit) status_set[ST_NOANS] = 1'b1;
        if ((state_q == S_STOP_WAIT) && finish) status_set[ST_AUTO] = 1'b1;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            arg_q    <= '0;
            status_q <= '0;
            resp_q   <= '0;
        end else begin
            if (cmd_wr && (state_q == S_IDLE)) begin
                cmd_q          <= cmd_wdata;
                cmd_q[CF_LOAD] <= 1'b0;
            end
            if (arg_wr && (state_q == S_IDLE)) arg_q <= arg_wdata;
            status_q <= (status_q & ~(stat_clr_wr ? stat_clr_mask : 32'd0)) | status_set;
            if (answer && cmd_q[CF_RESP] && len_ok) resp_q <= packed_words;
        end
    end

    assign cmd_reg    = cmd_q;
    assign arg_reg    = arg_q;
    assign raw_status = status_q;
    assign resp_word0 = resp_q[0];
    assign resp_word1 = resp_q[1];
    assign resp_word2 = resp_q[2];
    assign resp_word3 = resp_q[3];

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_req |=> !card_req);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cmd_wr || arg_wr)) |=> ($stable(cmd_reg) && $stable(arg_reg)));

    // R8
    stop_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STOP_WAIT) |-> ($stable(cmd_q) && $stable(arg_q)));

    // R8
    auto_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_status[ST_AUTO]) |-> ($past(state_q) == S_STOP_WAIT));

    // R6
    outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(raw_status[ST_NOANS]) && $rose(raw_status[ST_DONE])));

    // R3
    clkchg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_go && cmd_wdata[CF_CLKCHG]) |=> (!card_req && busy));

endmodule

// File: tb/test_sd_cmd_issue.sv
module test_sd_cmd_issue;
    localparam int unsigned TMO_W = 6;
    localparam int unsigned RB    = 16;
    localparam int unsigned LW    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wr = 0, arg_wr = 0, stat_clr_wr = 0;
    logic [31:0] cmd_wdata = 0, arg_wdata = 0, stat_clr_mask = 0;
    logic xfer_zero = 0, dma_done = 0, fifo_access = 0;
    logic [TMO_W-1:0] tmo_limit = 6'd20;
    logic card_req, busy;
    logic [5:0] card_cmd_idx;
    logic [31:0] card_arg, cmd_reg, arg_reg, raw_status;
    logic [31:0] resp_word0, resp_word1, resp_word2, resp_word3;
    logic card_resp_valid = 0;
    logic [LW-1:0] card_resp_len = 0;
    logic [8*RB-1:0] card_resp_bytes = 0;

    int checks = 0, fails = 0;
    int mdl_delay = 1, wcnt = 0, req_count = 0;
    logic pend = 0;
    logic [5:0] last_idx = 0, prev_idx = 0;
    logic [31:0] last_arg = 0;

    always #2 clk = ~clk;

    sd_cmd_issue #(.TMO_W(TMO_W), .RESP_BYTES(RB), .LEN_W(LW)) i_sd_cmd_issue (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .arg_wr(arg_wr), .arg_wdata(arg_wdata), .stat_clr_wr(stat_clr_wr),
        .stat_clr_mask(stat_clr_mask), .xfer_zero(xfer_zero), .dma_done(dma_done),
        .fifo_access(fifo_access), .tmo_limit(tmo_limit), .card_req(card_req),
        .card_cmd_idx(card_cmd_idx), .card_arg(card_arg),
        .card_resp_valid(card_resp_valid), .card_resp_len(card_resp_len),
        .card_resp_bytes(card_resp_bytes), .busy(busy), .cmd_reg(cmd_reg),
        .arg_reg(arg_reg), .resp_word0(resp_word0), .resp_word1(resp_word1),
        .resp_word2(resp_word2), .resp_word3(resp_word3), .raw_status(raw_status)
    );

    // card model: answers mdl_delay wait cycles after a request
    always @(negedge clk) begin
        card_resp_valid <= 1'b0;
        if (card_req) begin
            pend      <= 1'b1;
            wcnt      <= 0;
            req_count <= req_count + 1;
            prev_idx  <= last_idx;
            last_idx  <= card_cmd_idx;
            last_arg  <= card_arg;
        end else if (pend) begin
            if (wcnt == mdl_delay) begin
                card_resp_valid <= 1'b1;
                pend <= 1'b0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic check32(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic set_bytes(input logic [7:0] base);
        for (int i = 0; i < 16; i++) card_resp_bytes[8*i +: 8] = base + 8'(i);
    endtask

    function automatic logic [31:0] be_word(input logic [7:0] base, input int first);
        return {base + 8'(first), base + 8'(first + 1), base + 8'(first + 2), base + 8'(first + 3)};
    endfunction

    task automatic write_cmd(input logic [31:0] v);
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = v;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic write_arg(input logic [31:0] v);
        @(negedge clk); arg_wr = 1'b1; arg_wdata = v;
        @(negedge clk); arg_wr = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 300) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk); stat_clr_wr = 1'b1; stat_clr_mask = 32'hFFFF_FFFF;
        @(negedge clk); stat_clr_wr = 1'b0; stat_clr_mask = 0;
    endtask

    task automatic t_reset();
        check32("R10 reset busy", {31'd0, busy}, 32'd0);
        check32("R11 reset status", raw_status, 32'd0);
        check32("R1 reset cmd", cmd_reg, 32'd0);
        check32("R4 reset resp0", resp_word0, 32'd0);
        check32("R2 reset req", {31'd0, card_req}, 32'd0);
    endtask

    task automatic t_load_short();
        int r0;
        write_cmd(32'h0000_0011);
        @(negedge clk);
        check32("R1 plain write stored", cmd_reg, 32'h0000_0011);
        check32("R1 plain write no start", {31'd0, busy}, 32'd0);
        write_arg(32'hCAFE_0001);
        set_bytes(8'h10); card_resp_len = 5'd4; mdl_delay = 1;
        r0 = req_count;
        write_cmd(32'h8000_0051);
        check32("R1 load bit cleared", cmd_reg, 32'h0000_0051);
        check32("R2 request raised", {31'd0, card_req}, 32'd1);
        wait_idle();
        check32("R2 single request", 32'(req_count - r0), 32'd1);
        check32("R2 index", {26'd0, last_idx}, 32'd17);
        check32("R2 argument", last_arg, 32'hCAFE_0001);
        check32("R4 status done", raw_status, 32'h4);
        check32("R4 resp0 big-endian", resp_word0, be_word(8'h10, 0));
        check32("R4 resp1 cleared", resp_word1, 32'd0);
        clear_all();
    endtask

    task automatic t_long();
        set_bytes(8'hA0); card_resp_len = 5'd16; mdl_delay = 2;
        write_cmd(32'h8000_00C2);
        wait_idle();
        check32("R5 status done", raw_status, 32'h4);
        check32("R5 word0 bytes 12..15", resp_word0, be_word(8'hA0, 12));
        check32("R5 word1 bytes 8..11", resp_word1, be_word(8'hA0, 8));
        check32("R5 word2 bytes 4..7", resp_word2, be_word(8'hA0, 4));
        check32("R5 word3 bytes 0..3", resp_word3, be_word(8'hA0, 0));
        clear_all();
        // short after long clears words 1..3
        set_bytes(8'h30); card_resp_len = 5'd4;
        write_cmd(32'h8000_0043);
        wait_idle();
        check32("R4 word3 cleared after long", resp_word3, 32'd0);
        check32("R4 word0 new", resp_word0, be_word(8'h30, 0));
        clear_all();
    endtask

    task automatic t_mismatch();
        set_bytes(8'h55); card_resp_len = 5'd4; mdl_delay = 0;
        write_cmd(32'h8000_00C4);
        wait_idle();
        check32("R6 mismatch sets no-answer", raw_status, 32'h2);
        check32("R6 resp kept", resp_word0, be_word(8'h30, 0));
        clear_all();
        card_resp_len = 5'd16;
        write_cmd(32'h8000_0005);
        wait_idle();
        check32("R6 no response expected done", raw_status, 32'h4);
        check32("R6 no response kept", resp_word0, be_word(8'h30, 0));
        clear_all();
    endtask

    task automatic t_clkchg();
        int r0 = req_count;
        write_cmd(32'h8020_0043);
        wait_idle();
        check32("R3 no card request", 32'(req_count - r0), 32'd0);
        check32("R3 done status", raw_status, 32'h4);
        check32("R3 stored word", cmd_reg, 32'h0020_0043);
        clear_all();
    endtask

    task automatic t_timeout();
        tmo_limit = 6'd5; set_bytes(8'h70); card_resp_len = 5'd4;
        mdl_delay = 4;
        write_cmd(32'h8000_0046);
        wait_idle();
        check32("R7 answer at last cycle accepted", raw_status, 32'h4);
        check32("R7 resp stored", resp_word0, be_word(8'h70, 0));
        clear_all();
        set_bytes(8'h90); mdl_delay = 5;
        write_cmd(32'h8000_0046);
        wait_idle();
        repeat (3) @(negedge clk);
        check32("R7 late answer rejected", raw_status, 32'h2);
        check32("R7 resp unchanged", resp_word0, be_word(8'h70, 0));
        clear_all();
        tmo_limit = 6'd20;
    endtask

    task automatic t_autostop();
        int r0;
        set_bytes(8'h20); card_resp_len = 5'd4; mdl_delay = 1;
        write_arg(32'h0000_1234);
        xfer_zero = 1'b0; r0 = req_count;
        write_cmd(32'h8000_1052);
        wait_idle();
        check32("R12 no stop when count nonzero", 32'(req_count - r0), 32'd1);
        check32("R12 no auto bit", raw_status, 32'h4);
        clear_all();
        xfer_zero = 1'b1; r0 = req_count;
        write_cmd(32'h8000_1052);
        wait_idle();
        check32("R8 two requests", 32'(req_count - r0), 32'd2);
        check32("R8 first index", {26'd0, prev_idx}, 32'd18);
        check32("R8 stop index", {26'd0, last_idx}, 32'd12);
        check32("R8 stop argument", last_arg, 32'd0);
        check32("R8 command restored", cmd_reg, 32'h0000_1052);
        check32("R8 argument restored", arg_reg, 32'h0000_1234);
        check32("R8 status done and auto", raw_status, 32'h4004);
        clear_all();
        // R11 partial clear
        write_cmd(32'h8000_1052);
        wait_idle();
        @(negedge clk); stat_clr_wr = 1'b1; stat_clr_mask = 32'h4;
        @(negedge clk); stat_clr_wr = 1'b0;
        check32("R11 partial clear", raw_status, 32'h4000);
        clear_all();
    endtask

    task automatic t_events();
        int r0 = req_count;
        xfer_zero = 1'b1;
        @(negedge clk); fifo_access = 1'b1; @(negedge clk); fifo_access = 1'b0;
        wait_idle();
        check32("R9 fifo event stops", 32'(req_count - r0), 32'd1);
        check32("R9 fifo stop index", {26'd0, last_idx}, 32'd12);
        check32("R9 fifo auto bit", raw_status, 32'h4004);
        clear_all();
        r0 = req_count;
        @(negedge clk); dma_done = 1'b1; @(negedge clk); dma_done = 1'b0;
        wait_idle();
        check32("R9 dma event stops", 32'(req_count - r0), 32'd1);
        clear_all();
        xfer_zero = 1'b0; r0 = req_count;
        @(negedge clk); fifo_access = 1'b1; @(negedge clk); fifo_access = 1'b0;
        wait_idle();
        check32("R9 event ignored when nonzero", 32'(req_count - r0), 32'd0);
        check32("R9 no status", raw_status, 32'd0);
    endtask

    task automatic t_busy();
        int r0 = req_count;
        mdl_delay = 10; card_resp_len = 5'd4;
        write_cmd(32'h8000_0045);
        @(negedge clk);
        check32("R10 busy during wait", {31'd0, busy}, 32'd1);
        write_cmd(32'h8000_0049);
        write_arg(32'hDEAD_BEEF);
        wait_idle();
        check32("R10 single request", 32'(req_count - r0), 32'd1);
        check32("R10 command unchanged", cmd_reg, 32'h0000_0045);
        check32("R10 argument unchanged", arg_reg, 32'h0000_1234);
        clear_all();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_short();
        t_long();
        t_mismatch();
        t_clkchg();
        t_timeout();
        t_autostop();
        t_events();
        t_busy();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule